// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write a byte-wide asynchronous static RAM of 128K locations. The host side is a request/ready handshake: when the host raises a request while the controller signals ready, the controller takes the 17-bit address, the 8-bit write data and a write/read flag on that clock edge. It then runs one full memory cycle on its own. A read ends with the captured byte and a single-cycle valid pulse.

On the memory side the controller drives the address and four control strobes: an active-low select, an active-high select, an active-low output enable and an active-low write enable. The shared data pins are exposed as separate out, in and output-enable signals so that the tri-state pad sits outside the block. Between transactions both selects are left inactive, which keeps the memory in standby. Write cycles are timed by write enable with the output enable held inactive. After every read the controller leaves a dead time so that the memory's output drivers have released the bus before the controller can drive it.

All wait-state counts are fixed when the design is built. Each count is the ceiling of a nanosecond timing parameter divided by the clock period, and is never less than one cycle. With the default parameters (5 ns clock) these counts are: 4 access cycles, 1 setup cycle, 3 write-enable cycles and 2 turnaround cycles.

Top module: `sram_async_ctrl`

## Requirements
- R1: After a synchronous reset, and in every cycle with no transaction in flight, the outputs are `ready`=1, `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rd_valid`=0.
- R2: A request is taken only on a clock edge where `req`=1 and `ready`=1. From the next cycle `ready` stays 0 until the whole sequence for that request has finished, trailing wait included.
- R3: For the ACC_CYC cycles after a read is taken, the outputs are `mem_sel_n`=0, `mem_sel`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0, and `mem_addr` equals the requested address.
- R4: `rd_data` takes the value on `mem_dq_in` at the edge that ends the last access cycle. `rd_valid` is 1 for exactly the one cycle that follows that edge.
- R5: After the read access, the memory stays deselected with `mem_oe_n`=1, `mem_dq_oe`=0 and `ready`=0 for TURN_CYC cycles. Only then does the controller return to idle.
- R6: For the SETUP_CYC cycles after a write is taken, both selects are active, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0, and `mem_addr` holds the requested address.
- R7: Next, `mem_we_n` is 0 for PULSE_CYC cycles, with both selects active, `mem_oe_n`=1, `mem_dq_oe`=1 and `mem_dq_out` equal to the requested write data. PULSE_CYC covers both the minimum write-enable width and the data setup time.
- R8: After `mem_we_n` rises there is one more cycle with the selects active, `mem_dq_oe`=1, and the data and address unchanged. The controller then returns to idle.
- R9: `mem_oe_n` and `mem_we_n` are never low together, and `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R10: A request raised while `ready`=0 is ignored. The sequence in flight runs unchanged and the request is not taken later unless it is still present when `ready`=1.
- R11: While the memory stays selected from one cycle to the next, `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Host request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Host address |
| req_wdata | input | 8 | Host write data |
| ready | output | 1 | Controller idle and able to take a request |
| rd_valid | output | 1 | One-cycle pulse when rd_data holds new read data |
| rd_data | output | 8 | Captured read data |
| mem_addr | output | 17 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data arriving from the memory pins |
| mem_dq_oe | output | 1 | Enable of the pad driver for mem_dq_out |

## Verification
The assertions assume that `mem_dq_in` is settled by the edge that ends the access count, and that the host changes `req` and its fields only between clock edges. The stimulus meets both conditions. The bench's memory model answers combinationally whenever the memory is selected with output enable low and write enable high, and all host inputs are driven at the falling clock edge. Several times the host raises a request with unrelated address and data during a busy sequence, and always drops it before `ready` returns, so a request can be taken only through the normal handshake.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared types and build-time helpers for the SRAM controller.
// Assumes: timing values are positive integers in nanoseconds.
package sram_ctrl_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_ACC = 3'd1,
        ST_TURN   = 3'd2,
        ST_WR_SET = 3'd3,
        ST_WR_WE  = 3'd4,
        ST_WR_HLD = 3'd5
    } ctrl_state_t;

    // Memory-side strobe bundle produced by the decoder
    typedef struct packed {
        logic ready;
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    // Ceiling of t/p, never below one cycle
    function automatic int cyc_of(input int t_ns, input int p_ns);
        int c;
        c = (t_ns + p_ns - 1) / p_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Module: down-counting wait timer shared by every timed state.
// Loading N-1 on entry makes the state last N cycles; done is high
// while the count is zero. Assumes load values fit in CNT_W bits.
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load on state entry, else count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_decode.sv
// Module: maps the controller state to memory strobes and host ready.
// Pure decode from the registered state; assumes the state encoding
// of sram_ctrl_pkg. Output enable is asserted only in the read access.
module sram_strobe_decode
    import sram_ctrl_pkg::*;
(
    input  ctrl_state_t state,
    output strobe_t     strb
);

    // Per-state strobe levels
    always_comb begin
        strb = '{ready: 1'b0, sel_n: 1'b1, sel: 1'b0,
                 oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        unique case (state)
            ST_IDLE: begin
                strb.ready = 1'b1;
            end
            ST_RD_ACC: begin
                strb.sel_n = 1'b0;
                strb.sel   = 1'b1;
                strb.oe_n  = 1'b0;
            end
            ST_TURN: begin
                strb.ready = 1'b0;
            end
            ST_WR_SET: begin
                strb.sel_n = 1'b0;
                strb.sel   = 1'b1;
            end
            ST_WR_WE: begin
                strb.sel_n = 1'b0;
                strb.sel   = 1'b1;
                strb.we_n  = 1'b0;
                strb.dq_oe = 1'b1;
            end
            ST_WR_HLD: begin
                strb.sel_n = 1'b0;
                strb.sel   = 1'b1;
                strb.dq_oe = 1'b1;
            end
            default: begin
                strb.ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sram_rd_capture.sv
// Module: read-data capture register and one-cycle valid pulse.
// Assumes capture is high for exactly one cycle per read.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    // Latch bus data at the end of the access and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dq_in;
            end
        end
    end

    // A valid pulse is never stretched
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4

endmodule

// File: rtl/sram_async_ctrl.sv
// Module: host-to-asynchronous-SRAM access controller (top).
// Takes one request per handshake and runs a read (select + output
// enable for ACC_CYC cycles, then TURN_CYC idle cycles) or a write
// (SETUP_CYC select, PULSE_CYC write-enable low with data driven, one
// hold cycle). Assumes mem_dq_in settles within the access time and
// host inputs are stable around the clock edge.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 5,
    parameter int T_ACC_NS  = 20,
    parameter int T_AS_NS   = 0,
    parameter int T_WP_NS   = 15,
    parameter int T_DS_NS   = 9,
    parameter int T_TURN_NS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int ACC_CYC   = cyc_of(T_ACC_NS, CLK_NS);
    localparam int SETUP_CYC = cyc_of(T_AS_NS, CLK_NS);
    localparam int PULSE_CYC = imax(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_DS_NS, CLK_NS));
    localparam int TURN_CYC  = cyc_of(T_TURN_NS, CLK_NS);
    localparam int MAX_CYC   = imax(imax(ACC_CYC, SETUP_CYC), imax(PULSE_CYC, TURN_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    ctrl_state_t       state_q, state_d;
    logic              t_load, t_done, cap;
    logic [CNT_W-1:0]  t_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    strobe_t           strb;
    logic              take;

    assign take = req && (state_q == ST_IDLE);

    // Next-state and timer-load selection
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        cap     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    t_load = 1'b1;
                    if (req_wr) begin
                        state_d = ST_WR_SET;
                        t_val   = CNT_W'(SETUP_CYC - 1);
                    end else begin
                        state_d = ST_RD_ACC;
                        t_val   = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (t_done) begin
                    state_d = ST_TURN;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(TURN_CYC - 1);
                    cap     = 1'b1;
                end
            end
            ST_TURN: begin
                if (t_done) state_d = ST_IDLE;
            end
            ST_WR_SET: begin
                if (t_done) begin
                    state_d = ST_WR_WE;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(PULSE_CYC - 1);
                end
            end
            ST_WR_WE: begin
                if (t_done) state_d = ST_WR_HLD;
            end
            ST_WR_HLD: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request field registers, loaded only when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_strobe_decode u_decode (
        .state (state_q),
        .strb  (strb)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (cap),
        .dq_in    (mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign ready      = strb.ready;
    assign mem_sel_n  = strb.sel_n;
    assign mem_sel    = strb.sel;
    assign mem_oe_n   = strb.oe_n;
    assign mem_we_n   = strb.we_n;
    assign mem_dq_oe  = strb.dq_oe;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    logic selected;
    assign selected = !mem_sel_n && mem_sel;

    AST_READY_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready); // R2
    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (selected && mem_we_n && !mem_dq_oe)); // R3
    AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (selected && mem_dq_oe && mem_oe_n)); // R7
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && selected) |-> (mem_dq_oe && $stable(mem_dq_out))); // R8
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && (!mem_we_n || mem_dq_oe))); // R9
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && $past(selected)) |-> $stable(mem_addr)); // R11

endmodule

// File: tb/sram_async_ctrl_tb.sv
// Bench: behavioural per-cycle expectation queue plus a byte memory model.
module sram_async_ctrl_tb;

    localparam int CLK_PERIOD = 5;
    localparam int ACC   = (20 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int SETUP = 1;
    localparam int PULSE = (15 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int TURN  = (8 + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  rd_data, mem_dq_out;
    logic [7:0]  mem_dq_in = '0;
    logic [16:0] mem_addr;

    sram_async_ctrl #(.CLK_NS(CLK_PERIOD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    // Memory model and host-side shadow copy
    logic [7:0] mem [int];
    logic [7:0] shadow [int];

    function automatic logic [7:0] fill(input logic [16:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    always @(posedge mem_we_n) begin
        if (!mem_sel_n && mem_sel) mem[int'(mem_addr)] = mem_dq_out;
    end

    always @(mem_addr or mem_sel_n or mem_sel or mem_oe_n or mem_we_n) begin
        if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
            mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : fill(mem_addr);
        else
            mem_dq_in = 8'h00;
    end

    // Expected cycle: {ready, sel_n, sel, oe_n, we_n, dq_oe, rd_valid}
    typedef struct {
        logic [6:0]  ctl;
        logic [16:0] a;
        logic [7:0]  d;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_err = 0;
    bit   done_flag = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick(output bit was_idle);
        exp_t e;
        logic [6:0] act;
        @(negedge clk);
        if (q.size() != 0) begin
            e = q.pop_front();
            was_idle = 0;
        end else begin
            e.ctl = 7'b1101100; e.a = '0; e.d = '0; e.tag = "R1";
            was_idle = 1;
        end
        act = {ready, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid};
        check(act === e.ctl, e.tag, "strobes", 32'(act), 32'(e.ctl));
        if (!e.ctl[5]) check(mem_addr === e.a, e.tag, "addr", 32'(mem_addr), 32'(e.a));
        if (e.ctl[1]) check(mem_dq_out === e.d, e.tag, "dq_out", 32'(mem_dq_out), 32'(e.d));
        if (e.ctl[0]) check(rd_data === e.d, e.tag, "rd_data", 32'(rd_data), 32'(e.d));
    endtask

    function automatic void push(input logic [6:0] c, input logic [16:0] a,
                                 input logic [7:0] d, input string t);
        exp_t e;
        e.ctl = c; e.a = a; e.d = d; e.tag = t;
        q.push_back(e);
    endfunction

    // Wait for idle (optionally raising junk requests while busy), then issue
    task automatic op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                      input bit hammer);
        bit idle;
        logic [7:0] ed;
        idle = 0;
        while (!idle) begin
            tick(idle);
            if (!idle) begin
                req       = hammer;   // R10: must be ignored while busy
                req_wr    = ~wr;
                req_addr  = ~a;
                req_wdata = ~d;
            end
        end
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        if (wr) begin
            shadow[int'(a)] = d;
            for (int i = 0; i < SETUP; i++) push(7'b0011100, a, d, "R6");
            for (int i = 0; i < PULSE; i++) push(7'b0011010, a, d, "R7");
            push(7'b0011110, a, d, "R8");
        end else begin
            ed = shadow.exists(int'(a)) ? shadow[int'(a)] : fill(a);
            for (int i = 0; i < ACC; i++) push(7'b0010100, a, d, "R3");
            push(7'b0101101, a, ed, "R4");
            for (int i = 1; i < TURN; i++) push(7'b0101100, a, d, "R5");
        end
        tick(idle);   // first cycle of the new sequence; R2 ready low
        req = 1'b0;
    endtask

    task automatic drain();
        bit idle;
        idle = 0;
        while (!idle) tick(idle);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        bit idle;
        // R1: reset state, even with a request present
        req = 1'b1;
        for (int i = 0; i < 3; i++) tick(idle);
        req = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) tick(idle);
        // Basic write then read back
        op(1, 17'h00010, 8'hA5, 0);
        op(0, 17'h00010, 8'h00, 0);
        // Read of an unwritten location, then turnaround into a write (R5)
        op(0, 17'h1FFFF, 8'h00, 0);
        op(1, 17'h1FFFF, 8'h3C, 0);
        op(0, 17'h1FFFF, 8'h00, 0);
        // Back-to-back writes and reads with junk requests while busy (R10)
        op(1, 17'h00000, 8'hFF, 1);
        op(1, 17'h0AAAA, 8'h00, 1);
        op(0, 17'h00000, 8'h00, 1);
        op(0, 17'h0AAAA, 8'h00, 1);
        for (int i = 0; i < 8; i++) begin
            op(1, 17'(i * 4099), 8'(i * 37 + 1), i[0]);
        end
        for (int i = 0; i < 8; i++) begin
            op(0, 17'(i * 4099), 8'h00, ~i[0]);
        end
        // Overwrite and re-read
        op(1, 17'h00010, 8'h5A, 1);
        op(0, 17'h00010, 8'h00, 0);
        drain();
        for (int i = 0; i < 4; i++) tick(idle);  // R1 idle standby
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule